// File: doc/BRIEF.md
# Comparator Event Flag Path

This block turns one comparator trip signal into two results: a sticky event flag that software reads and clears, and a level event output that goes to a routing crossbar. A programmable glitch filter can be placed in the path. It samples the comparator at a prescaled rate into a window of recent samples and switches its output with hysteresis between two count thresholds. One select bit picks the raw comparator level or the filtered level, and that choice applies to the flag and to the event output together.

The two paths set the flag in different ways. On the raw path the flag follows the level, so it cannot stay cleared while the comparator is still high. On the filtered path the flag is set only by a rising edge of the filter output. A flag cleared while the filtered level stays high therefore stays cleared until that level falls and rises again. The event output is never gated by the edge logic.

Top module: `cmp_event_path`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, flag_out and evt_out are 0 and the filter output is low.
- R2: With path_sel = 0 (raw path), evt_out equals cmp_in one clock later, and a high cmp_in sets flag_out one clock later.
- R3: flag_out is sticky. A one-cycle flag_clr pulse drops it to 0 at the next clock when no set condition is present.
- R4: On the raw path, a flag_clr pulse while cmp_in is still high leaves flag_out reading 1 in the cycle after the pulse.
- R5: With path_sel = 1 (filtered path), flag_out is set one clock after the filter output rises. If it is cleared while the filter output stays high, it stays 0 until the filter output falls and rises again.
- R6: With path_sel = 1, evt_out equals the filter output one clock later, even while flag_out is cleared.
- R7: The filter takes one sample of cmp_in every filt_prescale+1 clocks and keeps the newest filt_win samples (1 to WIN_MAX). It goes high after a sample when the count of high samples is at least filt_hi_th. It goes low when that count is at most filt_lo_th, and otherwise it holds. The filter output changes in the same clock as the sample.
- R8: A filt_init pulse, or any change of filt_prescale, filt_win, filt_hi_th or filt_lo_th, drives the filter output low at the next clock. It also empties the sample window and restarts the sample phase.
- R9: When a set condition and flag_clr occur in the same cycle, flag_out is 1 after that clock.
- R10: The filtered edge detector holds 0 while the raw path is selected. Selecting the filtered path while the filter output is already high therefore sets flag_out one clock later.
- R11: A change of path_sel takes effect at the next clock. Switching to the raw path while cmp_in is low does not set flag_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 1 | Comparator trip level |
| filt_init | input | 1 | One-cycle pulse that restarts the glitch filter |
| filt_prescale | input | PRE_W | The filter samples once every filt_prescale+1 clocks |
| filt_win | input | CNT_W | Window length in samples (1 to WIN_MAX) |
| filt_hi_th | input | CNT_W | High-sample count at which the filter output goes high |
| filt_lo_th | input | CNT_W | High-sample count at which the filter output goes low |
| path_sel | input | 1 | 0 selects the raw path, 1 selects the filtered path |
| flag_clr | input | 1 | One-cycle flag clear strobe |
| flag_out | output | 1 | Sticky event flag |
| evt_out | output | 1 | Level event output toward the crossbar |

## Verification
The hardest condition to reach is a flag that is cleared while the filtered level is held high. Once it is cleared, nothing may set it until the filter falls and rises again. The stimulus first fills the window with high samples. It then clears the flag, holds the comparator high for ten clocks, and drops the comparator only far enough for the hysteresis to release the filter before raising it again. Two related edges are reached by exact cycle placement: the filter's rising cycle is lined up with a clear pulse, and the path select is toggled to raw and back while the filter output is still high.

// File: rtl/cep_pkg.sv
// Package cep_pkg: shared encoding for the comparator event flag path.
// Assumes nothing beyond the single select bit it names.
package cep_pkg;
    typedef enum logic {
        PATH_RAW  = 1'b0,
        PATH_FILT = 1'b1
    } path_e;
endpackage

// File: rtl/cep_prescaler.sv
// Module cep_prescaler: emits a one-clock sample strobe every rate+1 clocks.
// Assumes restart is held for one clock to realign the phase; strobe is low during restart.
module cep_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] rate,
    output logic             strobe
);
    logic [PRE_W-1:0] cnt_q;

    assign strobe = !restart && (cnt_q >= rate);

    // Phase counter: wraps on each strobe, zeroed on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || strobe) cnt_q <= '0;
        else                             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cep_glitch_filter.sv
// Module cep_glitch_filter: windowed majority filter with hysteresis on one input.
// Assumes filt_lo_th < filt_hi_th <= filt_win <= WIN_MAX; a config change or init flushes it.
module cep_glitch_filter #(
    parameter int WIN_MAX = 32,
    parameter int PRE_W   = 8,
    localparam int CNT_W  = $clog2(WIN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_in,
    input  logic             init,
    input  logic [PRE_W-1:0] prescale,
    input  logic [CNT_W-1:0] win,
    input  logic [CNT_W-1:0] hi_th,
    input  logic [CNT_W-1:0] lo_th,
    output logic             filt_q
);
    localparam int CFG_W = PRE_W + 3 * CNT_W;

    logic [CFG_W-1:0]   cfg_now, cfg_q;
    logic               flush, strobe;
    logic [WIN_MAX-1:0] win_mask, hist_q, hist_nx;
    logic [CNT_W-1:0]   cnt_nx;

    function automatic logic [CNT_W-1:0] ones_in(input logic [WIN_MAX-1:0] v);
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int b = 0; b < WIN_MAX; b++) acc = acc + CNT_W'(v[b]);
        return acc;
    endfunction

    assign cfg_now = {prescale, win, hi_th, lo_th};
    assign flush   = init || (cfg_now != cfg_q);

    // One mask bit per window position, enabled below the programmed length.
    for (genvar i = 0; i < WIN_MAX; i++) begin : g_mask
        assign win_mask[i] = (win > CNT_W'(i));
    end

    assign hist_nx = {hist_q[WIN_MAX-2:0], smp_in} & win_mask;
    assign cnt_nx  = ones_in(hist_nx);

    cep_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (flush),
        .rate    (prescale),
        .strobe  (strobe)
    );

    // Remember the configuration so any change triggers a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_now;
    end

    // Sample history and hysteresis output, both cleared on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hist_q <= '0;
            filt_q <= 1'b0;
        end else if (strobe) begin
            hist_q <= hist_nx;
            if (cnt_nx >= hi_th)      filt_q <= 1'b1;
            else if (cnt_nx <= lo_th) filt_q <= 1'b0;
        end
    end

    assert_flush_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !filt_q);

    assert_change_on_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> $past(strobe || flush));

    assert_hysteresis_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !flush && cnt_nx > lo_th && cnt_nx < hi_th) |=> $stable(filt_q));
endmodule

// File: rtl/cep_flag_ctrl.sv
// Module cep_flag_ctrl: sticky flag with a level set on the raw path and an edge set on the filtered path.
// Assumes flag_clr is a one-clock pulse; a set wins over a clear in the same clock.
module cep_flag_ctrl
    import cep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic path_sel,
    input  logic raw_lvl,
    input  logic filt_lvl,
    input  logic flag_clr,
    output logic flag_q
);
    logic  prev_q, set_req;
    path_e path;

    assign path    = path_e'(path_sel);
    assign set_req = (path == PATH_FILT) ? (filt_lvl && !prev_q) : raw_lvl;

    // Edge history: follows the filtered level only while that path is chosen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= (path == PATH_FILT) && filt_lvl;
    end

    // Sticky flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (set_req)  flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assert_raw_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!path_sel && raw_lvl) |=> flag_q);

    assert_no_reassert_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (path_sel && filt_lvl && prev_q && flag_clr) |=> !flag_q);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (path_sel && filt_lvl && !prev_q && flag_clr) |=> flag_q);

    assert_switch_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!path_sel && !raw_lvl && !flag_q) |=> !flag_q);
endmodule

// File: rtl/cmp_event_path.sv
// Module cmp_event_path: comparator trip conditioning into a sticky flag and a crossbar event level.
// Assumes cmp_in is already synchronous to clk; path_sel picks raw (0) or filtered (1) for both results.
module cmp_event_path
    import cep_pkg::*;
#(
    parameter int WIN_MAX = 32,
    parameter int PRE_W   = 8,
    localparam int CNT_W  = $clog2(WIN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_in,
    input  logic             filt_init,
    input  logic [PRE_W-1:0] filt_prescale,
    input  logic [CNT_W-1:0] filt_win,
    input  logic [CNT_W-1:0] filt_hi_th,
    input  logic [CNT_W-1:0] filt_lo_th,
    input  logic             path_sel,
    input  logic             flag_clr,
    output logic             flag_out,
    output logic             evt_out
);
    logic filt_lvl, sel_lvl;

    cep_glitch_filter #(.WIN_MAX(WIN_MAX), .PRE_W(PRE_W)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_in   (cmp_in),
        .init     (filt_init),
        .prescale (filt_prescale),
        .win      (filt_win),
        .hi_th    (filt_hi_th),
        .lo_th    (filt_lo_th),
        .filt_q   (filt_lvl)
    );

    cep_flag_ctrl u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .path_sel (path_sel),
        .raw_lvl  (cmp_in),
        .filt_lvl (filt_lvl),
        .flag_clr (flag_clr),
        .flag_q   (flag_out)
    );

    assign sel_lvl = (path_e'(path_sel) == PATH_FILT) ? filt_lvl : cmp_in;

    // Event level register: the selected level, never edge gated.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_out <= 1'b0;
        else        evt_out <= sel_lvl;
    end

    assert_evt_filtered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (path_sel && filt_lvl) |=> evt_out);

    assert_evt_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!path_sel && !cmp_in) |=> !evt_out);
endmodule

// File: tb/cmp_event_path_bench.sv
`timescale 1ns/1ps
module cmp_event_path_bench;
    localparam int WIN_MAX = 32;
    localparam int PRE_W   = 8;
    localparam int CNT_W   = $clog2(WIN_MAX + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cmp_in, filt_init, path_sel, flag_clr;
    logic [PRE_W-1:0] filt_prescale;
    logic [CNT_W-1:0] filt_win, filt_hi_th, filt_lo_th;
    logic             flag_out, evt_out;

    typedef struct {
        int    cyc;
        bit    chk_f;
        logic  f;
        bit    chk_e;
        logic  e;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    cmp_event_path #(.WIN_MAX(WIN_MAX), .PRE_W(PRE_W)) u_cmp_event_path (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmp_in        (cmp_in),
        .filt_init     (filt_init),
        .filt_prescale (filt_prescale),
        .filt_win      (filt_win),
        .filt_hi_th    (filt_hi_th),
        .filt_lo_th    (filt_lo_th),
        .path_sel      (path_sel),
        .flag_clr      (flag_clr),
        .flag_out      (flag_out),
        .evt_out       (evt_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops due items 2 ns after each edge and compares them.
    always @(posedge clk) begin
        #2;
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            if (it.cyc < cyc) begin
                n_chk++; n_fail++;
                $display("FAIL %s: item for cycle %0d missed at %0d", it.tag, it.cyc, cyc);
            end else begin
                if (it.chk_f) begin
                    n_chk++;
                    if (flag_out !== it.f) begin
                        n_fail++;
                        $display("FAIL %s: flag_out=%b expected %b (cycle %0d)", it.tag, flag_out, it.f, cyc);
                    end
                end
                if (it.chk_e) begin
                    n_chk++;
                    if (evt_out !== it.e) begin
                        n_fail++;
                        $display("FAIL %s: evt_out=%b expected %b (cycle %0d)", it.tag, evt_out, it.e, cyc);
                    end
                end
            end
        end
    end

    // Driver helpers: advance to 1 ns after an edge; queue an expectation n edges ahead.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_both(input int ahead, input logic f, input logic e, input string tag);
        exp_t it;
        it.cyc = cyc + ahead; it.chk_f = 1'b1; it.f = f; it.chk_e = 1'b1; it.e = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic expect_evt(input int ahead, input logic e, input string tag);
        exp_t it;
        it.cyc = cyc + ahead; it.chk_f = 1'b0; it.f = 1'b0; it.chk_e = 1'b1; it.e = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        rst_n = 1'b0; cmp_in = 1'b0; filt_init = 1'b0; path_sel = 1'b0; flag_clr = 1'b0;
        filt_prescale = '0; filt_win = 6'd4; filt_hi_th = 6'd3; filt_lo_th = 6'd1;
        tick(3);
        expect_both(0, 1'b0, 1'b0, "R1 in reset");
        cmp_in = 1'b1;
        tick(1);
        rst_n = 1'b1; cmp_in = 1'b0;
        expect_both(0, 1'b0, 1'b0, "R1 after reset");
        tick(8);

        // Raw path: level set, sticky, clear.
        cmp_in = 1'b1; expect_both(1, 1'b1, 1'b1, "R2 raw set"); tick(1);
        cmp_in = 1'b0; expect_both(1, 1'b1, 1'b0, "R3 sticky"); tick(1);
        flag_clr = 1'b1; expect_both(1, 1'b0, 1'b0, "R3 clear"); tick(1);
        flag_clr = 1'b0; tick(2);

        // Raw path: clear while comparator high has no lasting effect.
        cmp_in = 1'b1; tick(2);
        flag_clr = 1'b1; expect_both(1, 1'b1, 1'b1, "R4 raw clear while high"); tick(1);
        flag_clr = 1'b0; tick(1);
        cmp_in = 1'b0; tick(1);
        pulse_clr(); tick(6);

        // Filtered path: edge set three samples in, then clear while high.
        path_sel = 1'b1; expect_both(2, 1'b0, 1'b0, "R11 select filtered"); tick(2);
        cmp_in = 1'b1;
        expect_both(3, 1'b0, 1'b0, "R7 filter not yet high");
        expect_both(4, 1'b1, 1'b1, "R5 filtered edge set");
        tick(4);
        flag_clr = 1'b1; expect_both(1, 1'b0, 1'b1, "R6 evt while flag cleared"); tick(1);
        flag_clr = 1'b0; expect_both(10, 1'b0, 1'b1, "R5 no re-set while held"); tick(10);

        // Fall and rise again re-arms the edge.
        cmp_in = 1'b0;
        expect_both(3, 1'b0, 1'b1, "R7 fall delay");
        expect_both(4, 1'b0, 1'b0, "R6 evt falls");
        tick(4);
        cmp_in = 1'b1; expect_both(4, 1'b1, 1'b1, "R5 re-armed set"); tick(4);

        // Hysteresis: count 2 holds high, count 1 drops.
        pulse_clr();
        cmp_in = 1'b0;
        expect_evt(3, 1'b1, "R7 hysteresis hold");
        expect_evt(4, 1'b0, "R7 low threshold");
        tick(4); tick(2);

        // Short glitch of two samples is rejected.
        cmp_in = 1'b1;
        expect_both(3, 1'b0, 1'b0, "R7 glitch a");
        expect_both(4, 1'b0, 1'b0, "R7 glitch b");
        expect_both(7, 1'b0, 1'b0, "R7 glitch c");
        tick(2); cmp_in = 1'b0; tick(6);

        // Set and clear in the same cycle on the filtered path.
        cmp_in = 1'b1; tick(3);
        flag_clr = 1'b1; expect_both(1, 1'b1, 1'b1, "R9 set beats clear"); tick(1);
        flag_clr = 1'b0; tick(2);

        // Switch to raw with cmp low, then back while filter is high.
        pulse_clr();
        path_sel = 1'b0; cmp_in = 1'b0; expect_both(1, 1'b0, 1'b0, "R11 switch no set"); tick(1);
        path_sel = 1'b1; expect_both(1, 1'b1, 1'b1, "R10 already high counts as edge"); tick(1);

        // Re-initialise the filter while comparator held high.
        cmp_in = 1'b1; tick(4);
        pulse_clr();
        filt_init = 1'b1;
        expect_both(2, 1'b0, 1'b0, "R8 init output low");
        expect_both(4, 1'b0, 1'b0, "R8 history flushed");
        expect_both(5, 1'b1, 1'b1, "R8 refill then edge");
        tick(1); filt_init = 1'b0; tick(5);

        // Prescale change flushes and slows sampling to every third clock.
        pulse_clr();
        filt_prescale = 8'd2;
        expect_both(2, 1'b0, 1'b0, "R8 config change flush");
        expect_both(10, 1'b0, 1'b0, "R7 prescaled not yet");
        expect_both(11, 1'b1, 1'b1, "R7 prescaled rise");
        tick(12);

        tick(3);
        if (sb.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end
endmodule